// File: doc/BRIEF.md
# I2C Bus Recovery Controller

This block frees an I2C bus that a target device left hanging in the middle of a transfer. One common cause is a target that kept its power through a host reset. The block owns the bus lines as open-drain pins. It can pull SCL or SDA low or let either line float high, and it reads the real level of each line through a two-stage synchronizer. Outside logic starts a recovery with a one-cycle start pulse, gated by a grant input. A `busy` output lets shared logic make sure that only one bus is in recovery at any moment.

When started, the controller looks at both lines. A bus that is already idle finishes at once with success. If SCL is low, the controller polls it for a limited number of phases to wait out clock stretching. If SCL then frees up and SDA is low, the controller makes up to three attempts. Each attempt releases SCL and gives up to nine clock pulses, stopping early once SDA reads high. It then forces a STOP condition. After a STOP that leaves both lines high, the controller stops trying. The result is a one-cycle `done` pulse, an `ok` flag and a stuck flag for each line. The flags are held until the next accepted start.

Every bus phase lasts a fixed time of `PHASE_US` microseconds, counted in clock cycles from `CLK_HZ`. With the defaults (5 us) the bus clock is close to 100 kHz.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, `scl_low_o` and `sda_low_o` are 0 (both lines released), `busy_o` and `done_o` are 0, and `ok_o`, `scl_stuck_o` and `sda_stuck_o` are 0.
- R2: A start is taken only when `start_i` and `grant_i` are both 1 while `busy_o` is 0. A start without grant, or a start while busy, does not begin a recovery and does not change the recovery in progress.
- R3: If both lines read high when a start is taken, `done_o` pulses within 4 cycles with `ok_o`=1. The block pulls neither line low at any time during this run.
- R4: If SCL reads low when a start is taken, the block samples SCL once per phase, up to 10 samples. If SCL reads high at one of these samples, the block goes on to the SDA check without a failure.
- R5: If SCL is still low at the 10th sample, the run ends with `ok_o`=0, `scl_stuck_o`=1 and `sda_stuck_o`=0. The block drives neither line, and `done_o` rises between 10 and 10 plus 5 phases' worth of cycles after the start.
- R6: In each attempt the block gives at most 9 SCL pulses. A pulse is SCL pulled low for one phase, then released for one phase. SDA is checked before each pulse, and no further pulse is given once SDA reads high.
- R7: After the pulses of each attempt, the block pulls SDA low for exactly one phase while SCL is released, then releases SDA. This is a STOP condition. `sda_low_o` is never 1 while `scl_low_o` is 1.
- R8: After a STOP that leaves both lines high, the block makes no further attempts and reports `ok_o`=1. In any case it makes at most 3 attempts, so it sends at most 3 STOPs.
- R9: When the last attempt fails, `ok_o`=0. `sda_stuck_o` equals the inverse of the SDA level read at the end, and `scl_stuck_o` equals the inverse of the SCL level read at the end. With `ok_o`=1 both stuck flags are 0. With `ok_o`=0 at least one of them is 1.
- R10: `busy_o` is 1 from the cycle after a start is taken until `done_o`. `done_o` is 1 for a single cycle, and both lines are released whenever `busy_o` is 0.
- R11: One phase lasts CLK_HZ/1e6*PHASE_US clock cycles. Both an SCL low time and a STOP SDA low time last exactly one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a recovery (one-cycle pulse) |
| grant_i | input | 1 | Permission from outside logic; a start without it is ignored |
| scl_i | input | 1 | Level of the SCL line as seen at the pad |
| sda_i | input | 1 | Level of the SDA line as seen at the pad |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A recovery is in progress |
| done_o | output | 1 | One-cycle pulse when the recovery ends |
| ok_o | output | 1 | Both lines were high at the end |
| scl_stuck_o | output | 1 | SCL was still low at the end |
| sda_stuck_o | output | 1 | SDA was still low at the end |

## Verification
If the attempt or pulse counter holds a wrong value, the fault shows at the ports as a wrong number of SCL pulses or STOPs. It can be seen by the end of the run, at the latest after three attempts. A timer fault shows within the first phase as a low time that is not exactly one phase. If the state machine takes a wrong branch, it shows at the very next transition: SDA pulled low while SCL is low, a line driven while `busy_o` is low, or a `done_o` whose `ok_o` does not match the stuck flags.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_POLL,
        ST_REL,
        ST_PCHK,
        ST_PLO,
        ST_PHI,
        ST_SLO,
        ST_SHI,
        ST_FIN
    } unstick_st_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pin_drive_t;

    typedef struct packed {
        logic ok;
        logic scl_stuck;
        logic sda_stuck;
    } unstick_res_t;

    function automatic int phase_cycles(input longint clk_hz, input int us);
        longint c;
        c = (clk_hz / 64'd1000000) * longint'(us);
        return (c < 3) ? 3 : int'(c);
    endfunction

    function automatic pin_drive_t drive_of(input unstick_st_t s);
        pin_drive_t d;
        d.scl_low = (s == ST_PLO);
        d.sda_low = (s == ST_SLO);
        return d;
    endfunction

    function automatic logic is_timed(input unstick_st_t s);
        return (s == ST_POLL) || (s == ST_REL) || (s == ST_PLO) ||
               (s == ST_PHI) || (s == ST_SLO) || (s == ST_SHI);
    endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam int LAST = CYCLES - 1;

    logic [CW-1:0] cnt;

    assign tick_o = run_i && (cnt == CW'(LAST));

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import i2c_unstick_pkg::*;
#(
    parameter int POLLS    = 10,
    parameter int PULSES   = 9,
    parameter int ATTEMPTS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         grant_i,
    input  logic         scl_s,
    input  logic         sda_s,
    input  logic         tick_i,
    output unstick_st_t  state_o,
    output unstick_res_t res_o
);
    localparam int PW = $clog2(POLLS + 1);
    localparam int CW = $clog2(PULSES + 1);
    localparam int AW = $clog2(ATTEMPTS + 1);

    unstick_st_t  state, nxt;
    logic [PW-1:0] poll_cnt;
    logic [CW-1:0] pulse_cnt;
    logic [AW-1:0] att_cnt;
    unstick_res_t  res;

    logic last_poll, last_att, bus_free;
    assign last_poll = (poll_cnt == PW'(POLLS - 1));
    assign last_att  = (att_cnt == AW'(ATTEMPTS - 1));
    assign bus_free  = scl_s && sda_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i && grant_i) nxt = ST_CHECK;
            ST_CHECK: begin
                if (!scl_s)     nxt = ST_POLL;
                else if (sda_s) nxt = ST_FIN;
                else            nxt = ST_REL;
            end
            ST_POLL: begin
                if (tick_i) begin
                    if (scl_s)          nxt = ST_CHECK;
                    else if (last_poll) nxt = ST_FIN;
                end
            end
            ST_REL:  if (tick_i) nxt = ST_PCHK;
            ST_PCHK: begin
                if (sda_s || pulse_cnt == CW'(PULSES)) nxt = ST_SLO;
                else                                   nxt = ST_PLO;
            end
            ST_PLO:  if (tick_i) nxt = ST_PHI;
            ST_PHI:  if (tick_i) nxt = ST_PCHK;
            ST_SLO:  if (tick_i) nxt = ST_SHI;
            ST_SHI: begin
                if (tick_i) begin
                    if (bus_free || last_att) nxt = ST_FIN;
                    else                      nxt = ST_REL;
                end
            end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            poll_cnt  <= '0;
            pulse_cnt <= '0;
            att_cnt   <= '0;
            res       <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    poll_cnt <= '0;
                    att_cnt  <= '0;
                    if (start_i && grant_i) res <= '0;
                end
                ST_CHECK: begin
                    if (scl_s && sda_s) res.ok <= 1'b1;
                end
                ST_POLL: begin
                    if (tick_i && !scl_s) begin
                        if (last_poll) res.scl_stuck <= 1'b1;
                        else           poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_REL:  pulse_cnt <= '0;
                ST_PHI:  if (tick_i) pulse_cnt <= pulse_cnt + 1'b1;
                ST_SHI: begin
                    if (tick_i) begin
                        if (bus_free || last_att) begin
                            res.ok        <= bus_free;
                            res.scl_stuck <= !scl_s;
                            res.sda_stuck <= !sda_s;
                        end else begin
                            att_cnt <= att_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o = state;
    assign res_o   = res;
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import i2c_unstick_pkg::*;
#(
    parameter longint CLK_HZ   = 100_000_000,
    parameter int     PHASE_US = 5,
    parameter int     POLLS    = 10,
    parameter int     PULSES   = 9,
    parameter int     ATTEMPTS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic grant_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_low_o,
    output logic sda_low_o,
    output logic busy_o,
    output logic done_o,
    output logic ok_o,
    output logic scl_stuck_o,
    output logic sda_stuck_o
);
    localparam int PHASE = phase_cycles(CLK_HZ, PHASE_US);

    logic [1:0]   lines_s;
    logic         tick;
    unstick_st_t  state;
    unstick_res_t res;
    pin_drive_t   drv;

    unstick_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (lines_s)
    );

    unstick_timer #(.CYCLES(PHASE)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (is_timed(state)),
        .tick_o (tick)
    );

    unstick_fsm #(.POLLS(POLLS), .PULSES(PULSES), .ATTEMPTS(ATTEMPTS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .grant_i (grant_i),
        .scl_s   (lines_s[1]),
        .sda_s   (lines_s[0]),
        .tick_i  (tick),
        .state_o (state),
        .res_o   (res)
    );

    assign drv         = drive_of(state);
    assign scl_low_o   = drv.scl_low;
    assign sda_low_o   = drv.sda_low;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_FIN);
    assign ok_o        = res.ok;
    assign scl_stuck_o = res.scl_stuck;
    assign sda_stuck_o = res.sda_stuck;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int PULSES = 9
) (
    input logic clk,
    input logic rst,
    input logic scl_low_o,
    input logic sda_low_o,
    input logic busy_o,
    input logic done_o,
    input logic ok_o,
    input logic scl_stuck_o,
    input logic sda_stuck_o
);
    logic        scl_prev;
    logic [7:0]  pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev  <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            scl_prev <= scl_low_o;
            if (sda_low_o || !busy_o)        pulse_cnt <= '0;
            else if (scl_low_o && !scl_prev) pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_low_o && !sda_low_o)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)); // R10
    AST_STOP_SCL_FREE: assert property (@(posedge clk) disable iff (rst)
        sda_low_o |-> !scl_low_o); // R7
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= 8'(PULSES)); // R6
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> (!scl_stuck_o && !sda_stuck_o)); // R9
    AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (scl_stuck_o || sda_stuck_o)); // R9
endmodule

bind i2c_unstick i2c_unstick_chk #(.PULSES(PULSES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_low_o   (scl_low_o),
    .sda_low_o   (sda_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .scl_stuck_o (scl_stuck_o),
    .sda_stuck_o (sda_stuck_o)
);

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;
    localparam longint CLK_HZ = 10_000_000;
    localparam int     D      = 50;   // phase length in cycles for CLK_HZ, 5 us

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, grant_i = 1'b1;
    logic scl_low_o, sda_low_o, busy_o, done_o, ok_o, scl_stuck_o, sda_stuck_o;
    logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
    logic scl_line, sda_line;

    int nchk = 0, nerr = 0;
    int rel_after = 0;
    int bus_rises = 0, drv_pulses = 0, stops = 0, dones = 0;
    int scl_w = 0, scl_w_first = 0, sda_w = 0, sda_w_first = 0;
    logic pscl = 1'b1, pdrv = 1'b0, psda = 1'b0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign scl_line = !(scl_low_o || tgt_scl_low);
    assign sda_line = !(sda_low_o || tgt_sda_low);

    i2c_unstick #(.CLK_HZ(CLK_HZ)) i_i2c_unstick (
        .clk(clk), .rst(rst), .start_i(start_i), .grant_i(grant_i),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
        .done_o(done_o), .ok_o(ok_o), .scl_stuck_o(scl_stuck_o),
        .sda_stuck_o(sda_stuck_o)
    );

    // bus monitor and target model, sampled on the falling edge
    always @(negedge clk) begin
        if (scl_line && !pscl) begin
            bus_rises++;
            if (tgt_sda_low && bus_rises >= rel_after) tgt_sda_low = 1'b0;
        end
        if (scl_low_o && !pdrv) drv_pulses++;
        if (sda_low_o && !psda) stops++;
        if (scl_low_o) scl_w++;
        else if (pdrv && scl_w_first == 0) scl_w_first = scl_w;
        if (sda_low_o) sda_w++;
        else if (psda && sda_w_first == 0) sda_w_first = sda_w;
        if (done_o) dones++;
        pscl = scl_line; pdrv = scl_low_o; psda = sda_low_o;
    end

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        bus_rises = 0; drv_pulses = 0; stops = 0; dones = 0;
        scl_w = 0; scl_w_first = 0; sda_w = 0; sda_w_first = 0;
    endtask

    // sda_rel: release SDA after this many SCL rises (0 = SDA not held)
    // scl_hold: cycles the target holds SCL low after start (-1 forever)
    // restart_at: cycle at which a second start is pulsed (-1 none)
    task automatic run(input int sda_rel, input int scl_hold, input int restart_at,
                       output int cyc);
        rel_after   = sda_rel;
        tgt_sda_low = (sda_rel > 0);
        tgt_scl_low = (scl_hold != 0);
        repeat (5) @(negedge clk);
        clear_mon();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (scl_hold > 0 && cyc == scl_hold) tgt_scl_low = 1'b0;
            if (cyc == restart_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R10 idle after done", busy_o, 0);
        chk(!scl_low_o && !sda_low_o, "R10 lines released after done",
            {scl_low_o, sda_low_o}, 0);
        tgt_scl_low = 1'b0;
        tgt_sda_low = 1'b0;
    endtask

    task automatic t_reset();
        chk(!scl_low_o && !sda_low_o, "R1 lines released", {scl_low_o, sda_low_o}, 0);
        chk(!busy_o && !done_o, "R1 busy/done low", {busy_o, done_o}, 0);
        chk(!ok_o && !scl_stuck_o && !sda_stuck_o, "R1 results clear",
            {ok_o, scl_stuck_o, sda_stuck_o}, 0);
    endtask

    task automatic t_no_grant();
        grant_i = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(!busy_o && !scl_low_o && !sda_low_o, "R2 start without grant",
                busy_o, 0);
        end
        grant_i = 1'b1;
    endtask

    task automatic t_idle_bus();
        int cyc;
        run(0, 0, -1, cyc);
        chk(cyc <= 4, "R3 done latency", cyc, 4);
        chk(ok_o == 1'b1, "R3 ok", ok_o, 1);
        chk(drv_pulses == 0 && stops == 0, "R3 no drive", drv_pulses + stops, 0);
    endtask

    task automatic t_release_after(input int n, input int exp_stops, input string tag);
        int cyc;
        run(n, 0, -1, cyc);
        chk(ok_o && !scl_stuck_o && !sda_stuck_o, {tag, " R8 success"}, ok_o, 1);
        chk(drv_pulses == n, {tag, " R6 pulse count"}, drv_pulses, n);
        chk(stops == exp_stops, {tag, " R8 stop count"}, stops, exp_stops);
        chk(scl_w_first == D, {tag, " R11 scl low width"}, scl_w_first, D);
        chk(sda_w_first == D, {tag, " R7 stop sda width"}, sda_w_first, D);
    endtask

    task automatic t_sda_forever(input int restart_at);
        int cyc;
        run(100000, 0, restart_at, cyc);
        chk(!ok_o, "R9 fail", ok_o, 0);
        chk(sda_stuck_o && !scl_stuck_o, "R9 sda flag", {scl_stuck_o, sda_stuck_o}, 1);
        chk(drv_pulses == 27, "R6 nine pulses per attempt", drv_pulses, 27);
        chk(stops == 3, "R8 three attempts", stops, 3);
        chk(dones == 1, "R2 restart while busy ignored", dones, 1);
    endtask

    task automatic t_scl_forever();
        int cyc;
        run(0, -1, -1, cyc);
        chk(!ok_o && scl_stuck_o && !sda_stuck_o, "R5 scl stuck flags",
            {ok_o, scl_stuck_o, sda_stuck_o}, 2);
        chk(drv_pulses == 0 && stops == 0, "R5 no drive", drv_pulses + stops, 0);
        chk(cyc >= 10*D && cyc <= 10*D + 5, "R5 poll duration", cyc, 10*D);
    endtask

    task automatic t_scl_stretch();
        int cyc;
        run(0, 3*D, -1, cyc);
        chk(ok_o && !scl_stuck_o, "R4 stretch waited out", ok_o, 1);
        chk(drv_pulses == 0 && stops == 0, "R4 no recovery needed",
            drv_pulses + stops, 0);
        chk(cyc > 3*D && cyc <= 4*D + 6, "R4 sample per phase", cyc, 4*D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_grant();
        t_idle_bus();
        t_release_after(3, 1, "rel3");
        t_release_after(9, 1, "rel9");
        t_release_after(12, 2, "rel12");
        t_sda_forever(200);
        t_scl_forever();
        t_scl_stretch();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule